// File: doc/BRIEF.md
# PSRAM Chip-Enable Pulse Limiter

This block sits between a memory access sequencer and the active-low chip-enable lines of several external PSRAM banks. The sequencer raises an access request and names a bank. The limiter drives that bank's chip-enable low in the same cycle. PSRAM devices need chip-enable to go high now and then so they can refresh internally. The limiter therefore caps how long one chip-enable pulse may last. The cap is one shared programmable count, and each bank has its own bit that switches the cap on or off for that bank.

A down-timer is loaded with the count on every high-to-low transition of a bank's chip-enable. The timer steps once per clock while that line stays low. When the pulse has lasted the programmed number of cycles, the limiter splits the access. Chip-enable goes high for exactly one clock while a stall flag tells the sequencer to hold its address and data state. Chip-enable then falls again with a fresh count, and the sequencer re-issues its address phase. Splits work the same way whether the sequencer drives a synchronous or an asynchronous PSRAM access.

Top module: `psram_ce_limiter`

## Requirements
- R1: After reset, every chip-enable line is high (1) and the stall flag is low.
- R2: While the access request is high and no split is in progress, only the chip-enable line whose index equals the bank select is low, in the same cycle. With the request low, all lines are high.
- R3: For a bank whose enable bit is set, with a non-zero count N and the request held, chip-enable stays low for exactly N consecutive cycles before a split.
- R4: A split holds every chip-enable line high for exactly one cycle. Chip-enable then falls again, the timer is reloaded, and the next pulse again lasts N cycles, so a held request repeats a pattern of period N+1.
- R5: The stall flag is high exactly in a split cycle in which the request is still high. In that cycle every chip-enable line is high.
- R6: For a bank whose enable bit (bit index equal to the bank number) is clear, chip-enable follows the request for any length and no split occurs. The enable bits of other banks have no effect.
- R7: A count of zero disables splitting on every bank, whatever the enable bits are.
- R8: Dropping the request and raising it again starts a new pulse with the full count N.
- R9: If the request drops in the cycle right after the pulse reached N cycles, the stall flag stays low and all lines stay high. The next access again gets a full N-cycle pulse.
- R10: Changing the bank select while the request stays high counts as a new access on the new bank, which gets a full N-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_count | input | CNT_W (16) | Maximum chip-enable low time in cycles; 0 disables splitting |
| cfg_bank_en | input | NUM_BANKS (4) | Per-bank enable for the limiter; bit i belongs to bank i |
| acc_req | input | 1 | Sequencer requests chip-enable low |
| acc_bank | input | BANK_W (2) | Index of the bank being accessed |
| ce_n | output | NUM_BANKS (4) | Active-low chip-enable per bank |
| split_stall | output | 1 | High during a split cycle; the sequencer holds its state and then repeats the address phase |

## Verification
Two functions can fall in the same cycle: expiry of the timer and the sequencer ending or redirecting its access. The bench provokes the first case by holding the request for exactly N cycles and then dropping it, in the cycle where a split would otherwise stall. It judges the result by requiring the stall flag to stay low and the next access to receive a full N-cycle pulse. It provokes the second case by switching the bank select partway through a pulse. It then checks that the new bank's pulse length counts from the switch and not from the earlier start.

// File: rtl/psram_lim_pkg.sv
package psram_lim_pkg;

  // Cycles left in the current pulse, including the present one.
  function automatic logic [15:0] pl_remaining(input logic start,
                                               input logic [15:0] count,
                                               input logic [15:0] timer);
    return start ? count : timer;
  endfunction

  // Limiting is active only for an enabled bank with a non-zero count.
  function automatic logic pl_limit_on(input logic bank_bit,
                                       input logic [15:0] count);
    return bank_bit && (count != 16'd0);
  endfunction

  // The pulse has used its last allowed cycle.
  function automatic logic pl_expired(input logic ce_low,
                                      input logic limit_on,
                                      input logic [15:0] remaining);
    return ce_low && limit_on && (remaining == 16'd1);
  endfunction

endpackage

// File: rtl/pl_pulse_timer.sv
module pl_pulse_timer #(
  parameter int CNT_W  = 16,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_low,
  input  logic [BANK_W-1:0] bank,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              limit_on,
  output logic              expire,
  output logic              split_q
);
  import psram_lim_pkg::*;

  logic              low_q;
  logic [BANK_W-1:0] bank_q;
  logic [CNT_W-1:0]  timer_q;
  logic              start;
  logic [CNT_W-1:0]  remaining;

  assign start     = ce_low && (!low_q || (bank_q != bank));
  assign remaining = CNT_W'(pl_remaining(start, 16'(cfg_count), 16'(timer_q)));
  assign expire    = pl_expired(ce_low, limit_on, 16'(remaining));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= 1'b0;
      bank_q  <= '0;
      timer_q <= '0;
      split_q <= 1'b0;
    end else begin
      low_q   <= ce_low;
      bank_q  <= bank;
      split_q <= expire;
      if (ce_low) timer_q <= remaining - CNT_W'(1);
    end
  end

  // A split never begins two cycles in a row.
  AST_SPLIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    split_q |-> !expire); // R4

endmodule

// File: rtl/pl_bank_decode.sv
module pl_bank_decode #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 active,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] ce_n
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_line
    assign ce_n[b] = !(active && (bank == BANK_W'(b)));
  end

  always_comb begin
    AST_CE_EXCLUSIVE: assert ($onehot0(~ce_n)); // R2
  end

endmodule

// File: rtl/psram_ce_limiter.sv
module psram_ce_limiter #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cfg_count,
  input  logic [NUM_BANKS-1:0] cfg_bank_en,
  input  logic                 acc_req,
  input  logic [BANK_W-1:0]    acc_bank,
  output logic [NUM_BANKS-1:0] ce_n,
  output logic                 split_stall
);
  import psram_lim_pkg::*;

  logic active;
  logic limit_on;
  logic expire;
  logic split_q;

  assign active      = acc_req && !split_q;
  assign limit_on    = pl_limit_on(cfg_bank_en[acc_bank], 16'(cfg_count));
  assign split_stall = split_q && acc_req;

  pl_pulse_timer #(.CNT_W(CNT_W), .BANK_W(BANK_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_low    (active),
    .bank      (acc_bank),
    .cfg_count (cfg_count),
    .limit_on  (limit_on),
    .expire    (expire),
    .split_q   (split_q)
  );

  pl_bank_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) decode_i (
    .active (active),
    .bank   (acc_bank),
    .ce_n   (ce_n)
  );

  AST_STALL_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    split_stall |-> (&ce_n)); // R5
  AST_EXPIRY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (&ce_n)); // R4
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    split_stall |=> !split_stall); // R4
  AST_UNLIMITED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !limit_on && !split_q) |-> !ce_n[acc_bank]); // R6
  AST_NO_EXPIRY_UNLIMITED: assert property (@(posedge clk) disable iff (!rst_n)
    !limit_on |-> !expire); // R7

endmodule

// File: tb/psram_ce_limiter_tb_top.sv
module psram_ce_limiter_tb_top;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   cfg_count = '0;
  logic [NB-1:0] cfg_bank_en = '0;
  logic          acc_req = 1'b0;
  logic [1:0]    acc_bank = '0;
  logic [NB-1:0] ce_n;
  logic          split_stall;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  psram_ce_limiter #(.NUM_BANKS(NB), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_bank_en(cfg_bank_en),
    .acc_req(acc_req), .acc_bank(acc_bank), .ce_n(ce_n), .split_stall(split_stall)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected lines: only bank 'bk' low when 'low' is set.
  function automatic logic [NB-1:0] exp_ce(input bit low, input int bk);
    logic [NB-1:0] v = '1;
    if (low) v[bk] = 1'b0;
    return v;
  endfunction

  // One cycle: drive inputs at the falling edge, sample 1 ns later.
  task automatic step(input bit req, input int bk, input bit exp_low,
                      input bit exp_stall, input string tag);
    @(negedge clk);
    acc_req  = req;
    acc_bank = 2'(bk);
    #1;
    chk(ce_n == exp_ce(exp_low, bk), tag, int'(ce_n), int'(exp_ce(exp_low, bk)));
    chk(split_stall == exp_stall, tag, int'(split_stall), int'(exp_stall));
  endtask

  initial begin
    #1;
    chk(ce_n == '1, "R1", int'(ce_n), 'hf);
    chk(split_stall == 1'b0, "R1", int'(split_stall), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(ce_n == '1, "R1", int'(ce_n), 'hf);

    // Sweep banks, enable state and counts; the period is N+1 when limited.
    for (int b = 0; b < NB; b++) begin
      for (int en = 0; en < 2; en++) begin
        for (int n = 1; n <= 5; n++) begin
          cfg_count   = 16'(n);
          cfg_bank_en = en ? (NB'(1) << b) : ~(NB'(1) << b);
          for (int i = 0; i < 3 * (n + 1) + 2; i++) begin
            if (en) step(1'b1, b, (i % (n + 1)) < n, (i % (n + 1)) == n, "R3/R4/R5");
            else    step(1'b1, b, 1'b1, 1'b0, "R6");
          end
          step(1'b0, b, 1'b0, 1'b0, "R2");
          step(1'b0, b, 1'b0, 1'b0, "R2");
        end
      end
    end

    // R7: a zero count never splits, even with every bank enabled.
    cfg_count = 16'd0; cfg_bank_en = '1;
    for (int i = 0; i < 40; i++) step(1'b1, i / 10, 1'b1, 1'b0, "R7");
    step(1'b0, 0, 1'b0, 1'b0, "R7");

    // R8: drop the request mid-pulse, then raise it; the full count applies again.
    cfg_count = 16'd4;
    for (int i = 0; i < 2; i++) step(1'b1, 2, 1'b1, 1'b0, "R8");
    step(1'b0, 2, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 5; i++) step(1'b1, 2, i < 4, i == 4, "R8");
    step(1'b0, 2, 1'b0, 1'b0, "R8");

    // R9: the request drops in the cycle right after the pulse reaches N.
    cfg_count = 16'd3;
    for (int i = 0; i < 3; i++) step(1'b1, 1, 1'b1, 1'b0, "R9");
    step(1'b0, 1, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 4; i++) step(1'b1, 1, i < 3, i == 3, "R9");
    step(1'b0, 1, 1'b0, 1'b0, "R9");

    // R10: switching bank mid-pulse restarts the count on the new bank.
    cfg_count = 16'd4;
    for (int i = 0; i < 3; i++) step(1'b1, 0, 1'b1, 1'b0, "R10");
    for (int i = 0; i < 5; i++) step(1'b1, 3, i < 4, i == 4, "R10");
    step(1'b0, 3, 1'b0, 1'b0, "R10");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule